// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating state machines, one per table slot. Low-order bits of the branch address pick the slot. A combinational lookup port returns the guess for any address. A separate update port takes the resolved outcome of a branch and moves that slot's state machine one step. It also counts how many updates were seen and how many of them had been guessed right.

The step taken after a wrong guess from a weak state depends on a static policy input. With the policy at 0, the slot moves to the weak state of the other direction. With the policy at 1, it jumps to the strong state of the other direction. Every slot starts as weakly taken, so the first guess for any branch is taken. A fetch stage drives the lookup port. The resolving stage drives the update port, and its counters give a running measure of accuracy.

Top module: `branch_dir_predictor`

## Requirements
- R1: A slot holds a 2-bit state: 2'b11 strongly taken, 2'b10 weakly taken, 2'b01 weakly not taken, 2'b00 strongly not taken. `lk_taken` is the state's most significant bit: 1 in both taken states and 0 in both not-taken states.
- R2: While `rst` is high at a clock edge, every slot returns to weakly taken and both counters clear. After reset, `lk_taken` is 1 for every address and both counters read 0.
- R3: The slot index is address bits [IDX_W+1:2]. Two addresses that differ only outside those bits share one slot.
- R4: A correct outcome in a weak state moves the slot to the strong state of the same direction. A correct outcome in a strong state leaves the slot unchanged.
- R5: A wrong guess from a strong state moves the slot to the weak state of the same direction. For example, strongly taken followed by not taken gives weakly taken.
- R6: With `policy_sel` = 0, a wrong guess from a weak state moves the slot to the weak state of the opposite direction.
- R7: With `policy_sel` = 1, a wrong guess from a weak state moves the slot to the strong state of the opposite direction.
- R8: An update takes effect at the next clock edge. A lookup of the same slot in the update's own cycle returns the old guess.
- R9: `cnt_total` rises by one at each clock edge where `up_valid` is 1. No slot and no counter changes while `up_valid` is 0, whatever `up_addr`, `up_outcome` and `policy_sel` carry.
- R10: `cnt_correct` rises by one only when the slot's guess before the update equals `up_outcome`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_sel | input | 1 | Policy for a wrong guess from a weak state: 0 goes to the opposite weak state, 1 goes to the opposite strong state |
| lk_addr | input | ADDR_W | Branch address to look up |
| lk_taken | output | 1 | Guess for `lk_addr`: 1 means taken |
| up_valid | input | 1 | An update is present this cycle |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_outcome | input | 1 | Resolved direction: 1 means taken |
| cnt_total | output | CNT_W | Number of updates since reset |
| cnt_correct | output | CNT_W | Number of updates whose earlier guess was right |

## Verification
Directed runs repeat a single branch with four outcome patterns. A run of not-taken outcomes followed by taken outcomes gives a different guess sequence under each policy, so it separates the two weak-state policies. A taken-then-not-taken pair tests that a slot strengthens on a correct guess and steps back only one level after a wrong one. An alternating taken/not-taken run has a known count of 3 correct out of 5. Further directed cases cover same-cycle and aliased lookups and idle cycles whose update inputs are ignored. A long random phase then works on a few colliding slots while the policy changes, and compares every guess and both counters with a behavioural model on every cycle.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    BP_STRONG_NT = 2'b00,
    BP_WEAK_NT   = 2'b01,
    BP_WEAK_T    = 2'b10,
    BP_STRONG_T  = 2'b11
  } bp_state_e;

  localparam bp_state_e BP_INIT = BP_WEAK_T;

endpackage

// File: rtl/bp_state_table.sv
module bp_state_table
  import bp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx_a,
  output bp_state_e        rd_state_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output bp_state_e        rd_state_b,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  bp_state_e        wr_state
);

  localparam int DEPTH = 1 << IDX_W;

  bp_state_e slots [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        slots[i] <= BP_INIT;
      end
    end else if (wr_en) begin
      slots[wr_idx] <= wr_state;
    end
  end

  assign rd_state_a = slots[rd_idx_a];
  assign rd_state_b = slots[rd_idx_b];

endmodule

// File: rtl/bp_next_state.sv
module bp_next_state
  import bp_pkg::*;
(
  input  bp_state_e cur,
  input  logic      outcome,
  input  logic      policy_sel,
  output bp_state_e nxt,
  output logic      guess_ok
);

  assign guess_ok = (cur[1] == outcome);

  always_comb begin
    nxt = cur;
    unique case (cur)
      BP_STRONG_T:  nxt = outcome ? BP_STRONG_T : BP_WEAK_T;
      BP_WEAK_T:    nxt = outcome ? BP_STRONG_T
                                  : (policy_sel ? BP_STRONG_NT : BP_WEAK_NT);
      BP_WEAK_NT:   nxt = outcome ? (policy_sel ? BP_STRONG_T : BP_WEAK_T)
                                  : BP_STRONG_NT;
      BP_STRONG_NT: nxt = outcome ? BP_WEAK_NT : BP_STRONG_NT;
      default:      nxt = BP_INIT;
    endcase
  end

endmodule

// File: rtl/bp_tally.sv
module bp_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             hit,
  output logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] correct
);

  always_ff @(posedge clk) begin
    if (rst) begin
      total   <= '0;
      correct <= '0;
    end else if (inc) begin
      total <= total + 1'b1;
      if (hit) begin
        correct <= correct + 1'b1;
      end
    end
  end

endmodule

// File: rtl/branch_dir_predictor.sv
module branch_dir_predictor
  import bp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              policy_sel,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_taken,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_outcome,
  output logic [CNT_W-1:0]  cnt_total,
  output logic [CNT_W-1:0]  cnt_correct
);

  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_W + IDX_LO - 1;

  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  bp_state_e        lk_state;
  bp_state_e        upd_old;
  bp_state_e        upd_new;
  logic             upd_hit;

  assign lk_idx = lk_addr[IDX_HI:IDX_LO];
  assign up_idx = up_addr[IDX_HI:IDX_LO];

  bp_state_table #(.IDX_W(IDX_W)) u_table (
    .clk        (clk),
    .rst        (rst),
    .rd_idx_a   (lk_idx),
    .rd_state_a (lk_state),
    .rd_idx_b   (up_idx),
    .rd_state_b (upd_old),
    .wr_en      (up_valid),
    .wr_idx     (up_idx),
    .wr_state   (upd_new)
  );

  bp_next_state u_next (
    .cur        (upd_old),
    .outcome    (up_outcome),
    .policy_sel (policy_sel),
    .nxt        (upd_new),
    .guess_ok   (upd_hit)
  );

  bp_tally #(.CNT_W(CNT_W)) u_tally (
    .clk     (clk),
    .rst     (rst),
    .inc     (up_valid),
    .hit     (upd_hit),
    .total   (cnt_total),
    .correct (cnt_correct)
  );

  assign lk_taken = lk_state[1];

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int IDX_W = 6,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             up_valid,
  input logic             up_outcome,
  input logic             lk_taken,
  input logic [CNT_W-1:0] cnt_total,
  input logic [CNT_W-1:0] cnt_correct,
  input logic [IDX_W-1:0] lk_idx,
  input logic [IDX_W-1:0] up_idx,
  input logic [1:0]       upd_old,
  input logic [1:0]       upd_new
);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cnt_total == '0 && cnt_correct == '0 && lk_taken)); // R2

  AST_STRONG_KEEP: assert property (@(posedge clk) disable iff (rst)
    (up_valid && upd_old == 2'b11 && up_outcome) |-> (upd_new == 2'b11)); // R4

  AST_UPDATE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    ($past(up_valid) && !$past(rst) && lk_idx == $past(up_idx))
      |-> (lk_taken == $past(upd_new[1]))); // R8

  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> (cnt_total == $past(cnt_total) + 1'b1)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !up_valid |=> ($stable(cnt_total) && $stable(cnt_correct))); // R9

  AST_CORRECT_STEP: assert property (@(posedge clk) disable iff (rst)
    (up_valid && upd_old[1] == up_outcome)
      |=> (cnt_correct == $past(cnt_correct) + 1'b1)); // R10

  AST_CORRECT_MISS: assert property (@(posedge clk) disable iff (rst)
    (up_valid && upd_old[1] != up_outcome) |=> $stable(cnt_correct)); // R10

endmodule

bind branch_dir_predictor bp_checker #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .up_valid    (up_valid),
  .up_outcome  (up_outcome),
  .lk_taken    (lk_taken),
  .cnt_total   (cnt_total),
  .cnt_correct (cnt_correct),
  .lk_idx      (lk_idx),
  .up_idx      (up_idx),
  .upd_old     (upd_old),
  .upd_new     (upd_new)
);

// File: tb/tb_branch_dir_predictor.sv
module tb_branch_dir_predictor;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int IDX_W      = 6;
  localparam int CNT_W      = 16;
  localparam int SLOTS      = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst;
  logic              policy_sel;
  logic [ADDR_W-1:0] lk_addr;
  logic              lk_taken;
  logic              up_valid;
  logic [ADDR_W-1:0] up_addr;
  logic              up_outcome;
  logic [CNT_W-1:0]  cnt_total;
  logic [CNT_W-1:0]  cnt_correct;

  int checks = 0;
  int errors = 0;
  int mdl [SLOTS];
  int m_total;
  int m_correct;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_dir_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst(rst), .policy_sel(policy_sel),
    .lk_addr(lk_addr), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_addr(up_addr), .up_outcome(up_outcome),
    .cnt_total(cnt_total), .cnt_correct(cnt_correct)
  );

  function automatic int slot_of(logic [ADDR_W-1:0] a);
    return int'((a >> 2) % SLOTS);
  endfunction

  // Strength scale 0..3; the policy-1 jump is the only non-unit step.
  function automatic int advance(int s, bit t, bit p);
    if (t) begin
      if (p && s == 1) return 3;
      return (s == 3) ? 3 : s + 1;
    end
    if (p && s == 2) return 0;
    return (s == 0) ? 0 : s - 1;
  endfunction

  task automatic check(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < SLOTS; i++) mdl[i] = 2;
    m_total = 0;
    m_correct = 0;
  endtask

  // Called at a negedge; returns at the following negedge.
  task automatic cyc(bit pol, bit uv, logic [ADDR_W-1:0] ua, bit uo,
                     logic [ADDR_W-1:0] la, int exp_lk, string tag);
    int s;
    policy_sel = pol; up_valid = uv; up_addr = ua; up_outcome = uo; lk_addr = la;
    #1;
    check("R1 lookup vs model", int'(lk_taken), mdl[slot_of(la)] / 2);
    if (exp_lk >= 0) check(tag, int'(lk_taken), exp_lk);
    @(posedge clk);
    if (uv) begin
      s = mdl[slot_of(ua)];
      m_total++;
      if ((s / 2) == int'(uo)) m_correct++;
      mdl[slot_of(ua)] = advance(s, uo, pol);
    end
    @(negedge clk);
    check("R9 cnt_total", int'(cnt_total), m_total);
    check("R10 cnt_correct", int'(cnt_correct), m_correct);
  endtask

  task automatic do_reset();
    rst = 1; up_valid = 0; up_outcome = 0; policy_sel = 0;
    up_addr = '0; lk_addr = '0;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  localparam logic [ADDR_W-1:0] A  = 32'h0000_0010;
  localparam logic [ADDR_W-1:0] A2 = 32'h0000_0113; // same bits [7:2] as A
  localparam logic [ADDR_W-1:0] B  = 32'h0000_0014;

  initial begin
    model_reset();
    do_reset();

    // R2: reset state
    #1;
    check("R2 lk_taken after reset", int'(lk_taken), 1);
    lk_addr = 32'h0000_1234; #1;
    check("R2 lk_taken other addr", int'(lk_taken), 1);
    check("R2 cnt_total", int'(cnt_total), 0);
    check("R2 cnt_correct", int'(cnt_correct), 0);
    @(negedge clk);

    // R6 and R8 with policy 0
    cyc(0, 1, A, 0, A, 1, "R8 same-cycle lookup old");  // WT -> WN
    cyc(0, 1, A, 0, A, 0, "R6 WT miss to WN");          // WN -> SN
    cyc(0, 1, A, 1, A, 0, "R4 strengthen to SN");       // SN -> WN
    cyc(0, 1, A, 1, A, 0, "R5 SN miss to WN");          // WN -> WT
    cyc(0, 0, A, 0, A, 1, "R6 WN miss to WT");

    // R7 with policy 1
    do_reset();
    cyc(1, 1, A, 0, A, 1, "R7 before");                 // WT -> SN
    cyc(1, 1, A, 1, A, 0, "R7 WT miss to SN");          // SN -> WN
    cyc(1, 1, A, 1, A, 0, "R5 SN miss to WN");          // WN -> ST
    cyc(1, 1, A, 0, A, 1, "R7 WN miss to ST");          // ST -> WT
    cyc(1, 0, A, 0, A, 1, "R5 ST miss to WT");

    // R4: correct in weak strengthens, so one miss keeps it taken
    do_reset();
    cyc(0, 1, A, 1, A, 1, "R4 start");                  // WT -> ST
    cyc(0, 1, A, 0, A, 1, "R4 ST");                     // ST -> WT
    cyc(0, 1, A, 1, A, 1, "R4 ST miss stays taken");    // WT -> ST
    cyc(0, 1, A, 1, A, 1, "R4 ST saturates");           // ST -> ST
    cyc(0, 1, A, 0, A, 1, "R4 still taken");            // ST -> WT
    cyc(0, 0, A, 0, A, 1, "R4 WT after one miss");

    // R10/R9: alternating pattern gives 3 of 5
    do_reset();
    cyc(0, 1, A, 1, A, -1, "");
    cyc(0, 1, A, 0, A, -1, "");
    cyc(0, 1, A, 1, A, -1, "");
    cyc(0, 1, A, 0, A, -1, "");
    cyc(0, 1, A, 1, A, -1, "");
    check("R9 total after 5", int'(cnt_total), 5);
    check("R10 correct after 5", int'(cnt_correct), 3);

    // R3: aliasing
    do_reset();
    cyc(0, 1, A2, 0, A, 1, "R3 pre");
    cyc(0, 0, A2, 0, A, 0, "R3 alias shares slot");
    cyc(0, 0, A2, 0, B, 1, "R3 neighbour untouched");

    // R9: idle cycles ignore update fields
    for (int i = 0; i < 6; i++) begin
      cyc(i[0], 0, A, i[1], A, 0, "R9 idle keeps slot");
    end
    check("R9 idle total", int'(cnt_total), 1);
    check("R9 idle correct", int'(cnt_correct), 0);

    // Random phase over few colliding slots
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      logic [ADDR_W-1:0] ua, la;
      ua = {$urandom} & 32'h0000_031F;
      la = ($urandom_range(0, 3) == 0) ? ua : ({$urandom} & 32'h0000_031F);
      cyc(i[9], ($urandom_range(0, 4) != 0), ua, $urandom_range(0, 2) != 0,
          la, -1, "");
      if (i == 1500) do_reset();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule